// File: doc/BRIEF.md
# Link Power Management Request Sequencer

This block runs the host side of a USB Link Power Management (LPM) request. Software selects a channel, programs how many extra attempts are allowed, and pulses a start input. The block then issues two tokens toward a token generator: an extended-token prefix first, then the LPM token itself. Each token carries the device address and endpoint number stored for the chosen channel in a small internal table, which software fills through its own write port.

After both tokens are accepted, the block waits for the device's handshake. ACK, NYET and STALL end the request at once. ERROR starts a new attempt while attempts remain, and so does a silent device after a response timeout. A counter of the attempts still remaining can be read at the ports, and so can the handshake that ended the last request. The busy output acts as the start bit as software would read it back: it clears when the request finishes, whether or not the device gave a valid answer.

A separate timer drives a resume-permitted flag. The flag rises only after the link has stayed in the sleep state for a fixed residency time, given in clock cycles. It drops as soon as the sleep indication goes low.

Top module: `lpm_retry_seq`

## Requirements
- R1: A start pulse while idle makes the block present two tokens on the token port, one after the other: first tok_kind=0 (extended prefix), then tok_kind=1 (LPM). The next token is presented only after the current one has been accepted (tok_valid and tok_ready both high at a clock edge).
- R2: A handshake on rsp_code sampled while waiting ends the request. Codes are 0=ACK, 1=NYET, 2=STALL, 3=ERROR, and codes 0 to 2 are the valid handshakes. After a valid handshake, busy is low on the next cycle and last_rsp holds that code.
- R3: After an ERROR, the block repeats the two-token transaction if attempts remain. With a programmed count N, at most N+1 transactions are issued. When the last one fails, busy clears and last_rsp reads 3.
- R4: retries_left takes the value of cfg_retry_max when a request starts. It drops by one on each repeated attempt, and it keeps its final value after the request ends.
- R5: The tok_dev_addr and tok_ep of both tokens are the table entry selected by cfg_chan_idx at start. Entries are written through tbl_wr_en, tbl_wr_idx, tbl_wr_addr and tbl_wr_ep, and every entry resets to zero.
- R6: If no response arrives within RSP_TIMEOUT cycles of waiting, the block treats the silence as an ERROR.
- R7: A start pulse while busy has no effect on the channel, the count or the token stream. A response while idle changes neither busy nor last_rsp.
- R8: While tok_valid is high and tok_ready is low, tok_valid stays high and tok_kind, tok_dev_addr and tok_ep do not change.
- R9: resume_ok goes high after RESID_CYCLES consecutive clock edges with sleep_sts high, and not before.
- R10: resume_ok is low whenever sleep_sts is low. The residency count starts again from zero the next time sleep_sts goes high.
- R11: After reset, busy, tok_valid, retries_left, last_rsp and resume_ok are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Start request pulse |
| cfg_retry_max | input | RETRY_W | Number of extra attempts allowed after ERROR |
| cfg_chan_idx | input | CH_W | Channel selecting the table entry |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | CH_W | Table entry to write |
| tbl_wr_addr | input | ADDR_W | Device address to store |
| tbl_wr_ep | input | EP_W | Endpoint number to store |
| tok_valid | output | 1 | Token offered to the generator |
| tok_ready | input | 1 | Generator accepts the token |
| tok_kind | output | 1 | 0 = extended prefix, 1 = LPM token |
| tok_dev_addr | output | ADDR_W | Device address carried by the token |
| tok_ep | output | EP_W | Endpoint carried by the token |
| rsp_valid | input | 1 | Handshake present |
| rsp_code | input | 2 | 0 ACK, 1 NYET, 2 STALL, 3 ERROR |
| busy | output | 1 | Request in progress (start bit readback) |
| retries_left | output | RETRY_W | Attempts still remaining |
| last_rsp | output | 2 | Handshake that ended the last request |
| sleep_sts | input | 1 | Link is in the sleep state |
| resume_ok | output | 1 | Resume from sleep is permitted |

## Verification
A wrong retry counter shows up at the ports within one transaction. The block either sends one transaction too many or stops one early, so the scoreboard finds an extra token or a token that never arrives. The retries_left value read after each ERROR exposes an off-by-one on the very next cycle. A table or channel-latch fault changes the address or endpoint of the very first token after start, including when a stray start pulse arrives in the middle of a request. A fault in the residency counter moves the rising edge of resume_ok by at least one cycle from the expected edge, and a missing clear leaves the flag high on the cycle after sleep_sts falls.

// File: rtl/lpm_pkg.sv
// Shared encodings for the link power management request sequencer.
// Assumes: handshake codes arrive already decoded from the response path.
package lpm_pkg;

    typedef enum logic [1:0] {
        RSP_ACK   = 2'd0,
        RSP_NYET  = 2'd1,
        RSP_STALL = 2'd2,
        RSP_ERR   = 2'd3
    } rsp_code_e;

    typedef enum logic {
        TOK_EXT = 1'b0,
        TOK_LPM = 1'b1
    } tok_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SEND_EXT = 2'd1,
        ST_SEND_LPM = 2'd2,
        ST_WAIT     = 2'd3
    } seq_state_e;

endpackage

// File: rtl/lpm_chan_table.sv
// Per-channel target table: one device address and one endpoint per channel.
// Assumes: one write per cycle; the read is combinational on the index.
module lpm_chan_table #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4,
    parameter int ADDR_W = 7,
    parameter int EP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [EP_W-1:0]   wr_ep,
    input  logic [CH_W-1:0]   rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [EP_W-1:0]   rd_ep
);

    logic [ADDR_W-1:0] addr_q [NUM_CH];
    logic [EP_W-1:0]   ep_q   [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
        // Purpose: hold one entry, cleared by reset and loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
                ep_q[g]   <= '0;
            end else if (wr_en && (wr_idx == CH_W'(g))) begin
                addr_q[g] <= wr_addr;
                ep_q[g]   <= wr_ep;
            end
        end
    end

    // Purpose: select the entry named by the read index.
    always_comb begin
        rd_addr = '0;
        rd_ep   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_idx == CH_W'(i)) begin
                rd_addr = addr_q[i];
                rd_ep   = ep_q[i];
            end
        end
    end

endmodule

// File: rtl/lpm_seq_fsm.sv
// Request sequencer: sends the prefix and LPM tokens, waits for a handshake,
// and repeats on ERROR or timeout until the attempts run out.
// Assumes: cfg_start is a one-cycle pulse; rsp_valid counts only while waiting.
module lpm_seq_fsm
    import lpm_pkg::*;
#(
    parameter int CH_W        = 4,
    parameter int RETRY_W     = 3,
    parameter int RSP_TIMEOUT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RETRY_W-1:0] retry_max,
    input  logic [CH_W-1:0]    chan_idx,
    input  logic               tok_ready,
    input  logic               rsp_valid,
    input  logic [1:0]         rsp_code,
    output logic               tok_valid,
    output logic               tok_kind,
    output logic [CH_W-1:0]    chan_sel,
    output logic               busy,
    output logic [RETRY_W-1:0] retries_left,
    output logic [1:0]         last_rsp
);

    localparam int TMO_W = (RSP_TIMEOUT > 1) ? $clog2(RSP_TIMEOUT) : 1;
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(RSP_TIMEOUT - 1);

    seq_state_e         st_q;
    logic [TMO_W-1:0]   tmo_q;
    logic [RETRY_W-1:0] left_q;
    logic [CH_W-1:0]    chan_q;
    logic [1:0]         last_q;
    logic               good_rsp;
    logic               fail_rsp;

    assign good_rsp = rsp_valid && (rsp_code != RSP_ERR);
    assign fail_rsp = (rsp_valid && (rsp_code == RSP_ERR)) || (!rsp_valid && (tmo_q == TMO_LAST));

    // Purpose: advance the request through its phases and keep the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            tmo_q  <= '0;
            left_q <= '0;
            chan_q <= '0;
            last_q <= RSP_ACK;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        left_q <= retry_max;
                        chan_q <= chan_idx;
                        st_q   <= ST_SEND_EXT;
                    end
                end
                ST_SEND_EXT: begin
                    if (tok_ready) st_q <= ST_SEND_LPM;
                end
                ST_SEND_LPM: begin
                    if (tok_ready) begin
                        st_q  <= ST_WAIT;
                        tmo_q <= '0;
                    end
                end
                ST_WAIT: begin
                    if (good_rsp) begin
                        last_q <= rsp_code;
                        st_q   <= ST_IDLE;
                    end else if (fail_rsp) begin
                        if (left_q == '0) begin
                            last_q <= RSP_ERR;
                            st_q   <= ST_IDLE;
                        end else begin
                            left_q <= left_q - 1'b1;
                            st_q   <= ST_SEND_EXT;
                        end
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign tok_valid    = (st_q == ST_SEND_EXT) || (st_q == ST_SEND_LPM);
    assign tok_kind     = (st_q == ST_SEND_LPM);
    assign chan_sel     = chan_q;
    assign busy         = (st_q != ST_IDLE);
    assign retries_left = left_q;
    assign last_rsp     = last_q;

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(chan_q)); // R7
    AST_RETRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (left_q == $past(left_q)) || (left_q == RETRY_W'($past(left_q) - 1'b1))); // R4
    AST_VALID_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && good_rsp) |=> (!busy && last_q == $past(rsp_code))); // R2
    AST_EXHAUST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && !good_rsp && fail_rsp && left_q == '0) |=> (!busy && last_q == RSP_ERR)); // R3
    AST_TIMEOUT_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && !rsp_valid && tmo_q == TMO_LAST && left_q != '0) |=> (st_q == ST_SEND_EXT)); // R6

endmodule

// File: rtl/lpm_resume_timer.sv
// Sleep residency timer: permits resume after the link has slept long enough.
// Assumes: sleep_sts is synchronous to clk; RESID_CYCLES is at least 1.
module lpm_resume_timer #(
    parameter int RESID_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_sts,
    output logic resume_ok
);

    localparam int CNT_W = $clog2(RESID_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(RESID_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESID_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ok_q;

    // Purpose: count residency while asleep and clear everything when awake.
    always_ff @(posedge clk) begin
        if (!rst_n || !sleep_sts) begin
            cnt_q <= '0;
            ok_q  <= 1'b0;
        end else if (cnt_q != CNT_END) begin
            cnt_q <= cnt_q + 1'b1;
            ok_q  <= (cnt_q == CNT_LAST);
        end
    end

    assign resume_ok = ok_q && sleep_sts;

    AST_RESUME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_sts |=> (!ok_q && cnt_q == '0)); // R10
    AST_RESUME_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_q) |-> (cnt_q == CNT_END)); // R9

endmodule

// File: rtl/lpm_retry_seq.sv
// Top of the link power management request sequencer: channel table,
// request sequencer and sleep residency timer.
// Assumes: a single clock domain; the token generator follows valid/ready.
module lpm_retry_seq #(
    parameter int CH_W         = 4,
    parameter int ADDR_W       = 7,
    parameter int EP_W         = 4,
    parameter int RETRY_W      = 3,
    parameter int RSP_TIMEOUT  = 64,
    parameter int CLK_MHZ      = 100,
    parameter int RESID_US     = 50,
    parameter int RESID_CYCLES = CLK_MHZ * RESID_US
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_start,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    input  logic [CH_W-1:0]    cfg_chan_idx,
    input  logic               tbl_wr_en,
    input  logic [CH_W-1:0]    tbl_wr_idx,
    input  logic [ADDR_W-1:0]  tbl_wr_addr,
    input  logic [EP_W-1:0]    tbl_wr_ep,
    output logic               tok_valid,
    input  logic               tok_ready,
    output logic               tok_kind,
    output logic [ADDR_W-1:0]  tok_dev_addr,
    output logic [EP_W-1:0]    tok_ep,
    input  logic               rsp_valid,
    input  logic [1:0]         rsp_code,
    output logic               busy,
    output logic [RETRY_W-1:0] retries_left,
    output logic [1:0]         last_rsp,
    input  logic               sleep_sts,
    output logic               resume_ok
);

    localparam int NUM_CH = 1 << CH_W;

    logic [CH_W-1:0] chan_sel;

    lpm_chan_table #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W), .EP_W(EP_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_addr(tbl_wr_addr), .wr_ep(tbl_wr_ep),
        .rd_idx(chan_sel), .rd_addr(tok_dev_addr), .rd_ep(tok_ep)
    );

    lpm_seq_fsm #(
        .CH_W(CH_W), .RETRY_W(RETRY_W), .RSP_TIMEOUT(RSP_TIMEOUT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(cfg_start), .retry_max(cfg_retry_max), .chan_idx(cfg_chan_idx),
        .tok_ready(tok_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .chan_sel(chan_sel),
        .busy(busy), .retries_left(retries_left), .last_rsp(last_rsp)
    );

    lpm_resume_timer #(
        .RESID_CYCLES(RESID_CYCLES)
    ) u_resume (
        .clk(clk), .rst_n(rst_n), .sleep_sts(sleep_sts), .resume_ok(resume_ok)
    );

    AST_TOK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_kind)
            && $stable(tok_dev_addr) && $stable(tok_ep))); // R8
    AST_PREFIX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tok_valid) |-> (tok_kind == 1'b0)); // R1
    AST_LPM_AFTER_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready && !tok_kind) |=> (tok_valid && tok_kind)); // R1

endmodule

// File: tb/lpm_retry_seq_tb_top.sv
// Scoreboard bench: the driver queues the expected tokens, the monitor compares.
module lpm_retry_seq_tb_top;

    localparam int CH_W = 4, ADDR_W = 7, EP_W = 4, RETRY_W = 3;
    localparam int TMO = 8, RESID = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_start = 1'b0;
    logic [RETRY_W-1:0] cfg_retry_max = '0;
    logic [CH_W-1:0] cfg_chan_idx = '0;
    logic tbl_wr_en = 1'b0;
    logic [CH_W-1:0] tbl_wr_idx = '0;
    logic [ADDR_W-1:0] tbl_wr_addr = '0;
    logic [EP_W-1:0] tbl_wr_ep = '0;
    logic tok_valid, tok_kind, tok_ready = 1'b1;
    logic [ADDR_W-1:0] tok_dev_addr;
    logic [EP_W-1:0] tok_ep;
    logic rsp_valid = 1'b0;
    logic [1:0] rsp_code = '0;
    logic busy, resume_ok, sleep_sts = 1'b0;
    logic [RETRY_W-1:0] retries_left;
    logic [1:0] last_rsp;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit stall_en = 1'b0, done = 1'b0;
    logic [3:0] rdy_cnt = '0;
    logic [11:0] exp_q [$];

    always #5 clk = ~clk;

    lpm_retry_seq #(
        .CH_W(CH_W), .ADDR_W(ADDR_W), .EP_W(EP_W), .RETRY_W(RETRY_W),
        .RSP_TIMEOUT(TMO), .CLK_MHZ(1), .RESID_US(RESID)
    ) dut_i (.*);

    function automatic logic [ADDR_W-1:0] addr_of(int ch);
        return ADDR_W'(7'h11 + ch * 5);
    endfunction
    function automatic logic [EP_W-1:0] ep_of(int ch);
        return EP_W'(ch ^ 9);
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Ready pattern, changed just after the edge so the negedge view is settled.
    always @(posedge clk) begin
        #2;
        rdy_cnt <= rdy_cnt + 1'b1;
        tok_ready <= !stall_en || (rdy_cnt[1:0] == 2'd3);
    end

    // Monitor: every accepted token must match the head of the queue (R1, R5, R8).
    always @(negedge clk) begin
        if (rst_n && tok_valid && tok_ready) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R3 unexpected token actual=%0h expected=none",
                         {tok_kind, tok_dev_addr, tok_ep});
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check("R1/R5 token", int'({tok_kind, tok_dev_addr, tok_ep}), int'(e));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            summary();
        end
    end

    // Driver: code -1 means the device stays silent.
    task automatic run_seq(int rmax, int ch, int codes[8], bit inject);
        int attempts = rmax + 1, final_code = 3;
        for (int a = 0; a <= rmax; a++) begin
            if (codes[a] >= 0 && codes[a] != 3) begin
                attempts = a + 1; final_code = codes[a]; break;
            end
        end
        for (int a = 0; a < attempts; a++) begin
            exp_q.push_back({1'b0, addr_of(ch), ep_of(ch)});
            exp_q.push_back({1'b1, addr_of(ch), ep_of(ch)});
        end
        @(negedge clk);
        cfg_start = 1'b1; cfg_retry_max = RETRY_W'(rmax); cfg_chan_idx = CH_W'(ch);
        @(negedge clk);
        cfg_start = 1'b0;
        check("R4 load", int'(retries_left), rmax);
        for (int a = 0; a < attempts; a++) begin
            int guard = 0;
            while (!(tok_valid && tok_ready && tok_kind) && guard < 200) begin
                @(negedge clk); guard++;
            end
            @(negedge clk);
            if (codes[a] >= 0) begin
                rsp_valid = 1'b1; rsp_code = 2'(codes[a]);
                if (inject && a == 0) begin
                    cfg_start = 1'b1; cfg_chan_idx = CH_W'(ch ^ 5); cfg_retry_max = '1;
                end
                @(negedge clk);
                rsp_valid = 1'b0; cfg_start = 1'b0;
                if (codes[a] == 3 && a < rmax)
                    check("R4 decrement", int'(retries_left), rmax - a - 1);
            end
        end
        for (int g = 0; g < 200 && busy; g++) @(negedge clk);
        check("R2/R3 busy clear", int'(busy), 0);
        check("R2/R3 last_rsp", int'(last_rsp), final_code);
        check("R4 final count", int'(retries_left), rmax - attempts + 1);
        check("R3 no missing token", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy", int'(busy), 0);
        check("R11 tok_valid", int'(tok_valid), 0);
        check("R11 retries_left", int'(retries_left), 0);
        check("R11 last_rsp", int'(last_rsp), 0);
        check("R11 resume_ok", int'(resume_ok), 0);
        rst_n = 1'b1;
        // R5: fill the channel table
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            tbl_wr_en = 1'b1; tbl_wr_idx = CH_W'(c);
            tbl_wr_addr = addr_of(c); tbl_wr_ep = ep_of(c);
        end
        @(negedge clk); tbl_wr_en = 1'b0;

        run_seq(3, 2, '{0, 0, 0, 0, 0, 0, 0, 0}, 1'b0);       // R2 ACK at once
        stall_en = 1'b1;                                       // R8 back-pressure
        run_seq(2, 5, '{3, 1, 0, 0, 0, 0, 0, 0}, 1'b0);       // R3 ERROR then NYET
        stall_en = 1'b0;
        run_seq(1, 9, '{3, 3, 0, 0, 0, 0, 0, 0}, 1'b0);       // R3 exhaustion
        run_seq(0, 15, '{2, 0, 0, 0, 0, 0, 0, 0}, 1'b0);      // R2 STALL, no retries
        run_seq(2, 0, '{-1, 3, 0, 0, 0, 0, 0, 0}, 1'b0);      // R6 timeout, ERROR, ACK
        run_seq(1, 4, '{-1, -1, 0, 0, 0, 0, 0, 0}, 1'b0);     // R6 timeouts exhaust
        run_seq(2, 3, '{3, 3, 3, 0, 0, 0, 0, 0}, 1'b1);       // R7 start while busy
        run_seq(7, 12, '{3, 3, 3, 3, 3, 3, 3, 3}, 1'b0);      // R3 full count

        // R7: response while idle
        @(negedge clk); rsp_valid = 1'b1; rsp_code = 2'd1;
        @(negedge clk); rsp_valid = 1'b0;
        check("R7 idle rsp busy", int'(busy), 0);
        check("R7 idle rsp last_rsp", int'(last_rsp), 3);
        check("R7 idle rsp no token", int'(tok_valid), 0);

        // R9: residency timing
        @(negedge clk); sleep_sts = 1'b1;
        repeat (RESID - 1) @(negedge clk);
        check("R9 early", int'(resume_ok), 0);
        @(negedge clk);
        check("R9 on time", int'(resume_ok), 1);
        // R10: drop and restart
        sleep_sts = 1'b0; #1;
        check("R10 low when awake", int'(resume_ok), 0);
        @(negedge clk); sleep_sts = 1'b1;
        repeat (RESID / 2) @(negedge clk);
        check("R10 count restarted", int'(resume_ok), 0);
        repeat (RESID - RESID / 2) @(negedge clk);
        check("R9 second rise", int'(resume_ok), 1);

        done = 1'b1;
        summary();
    end

endmodule